// File: doc/BRIEF.md
# DMA Descriptor Fetch Sequencer

This block runs once each time a DMA channel is started, or finishes a unit of work whose flow mode asks for a new descriptor. It takes a snapshot of the channel's config, pointer, count and modify registers. It checks that the flow mode and the descriptor size go together. When the mode is a descriptor mode, it reads the descriptor as a chain of 16-bit words over a request/response memory port and writes each word into a working copy of the register set. At the end it derives the element size, checks the alignment of the start address, and presents the current descriptor pointer, current address and current counts together with a one-cycle `done` flag.

Each word written into the working copy also appears on an update strobe (`upd_valid`, `upd_slot`, `upd_data`), so that the channel's register file can track it. The memory port uses valid/ready in both directions:
- A request holds `req_valid` and `req_addr` stable until `req_ready` is seen.
- The sequencer keeps at most one read outstanding.
- `rsp_ready` is high only while a response is awaited, and a word is stored only in a cycle with `rsp_valid && rsp_ready`.
- Either side may stall for any number of cycles.

Top module: `dma_desc_fetch`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `req_valid` and `upd_valid` are 0, and every current and working output is 0.
- R2: In flow modes stop (config[14:12]=0) and autobuffer (config[14:12]=1) with a descriptor size (config[11:8]) of 0, no memory request is made. `done` pulses for one cycle, and the outputs take their values from the input registers: current descriptor pointer from the next pointer, current address from the start address, and modify and config values unchanged.
- R3: A size that the mode does not allow makes `done` and `err` pulse together, with no memory request and all current and working outputs left unchanged. The allowed sizes are 0 for stop and autobuffer, 1..7 for array (mode 4), 1..8 for small list (mode 6) and 1..9 for large list (mode 7). Modes 2, 3 and 5 are undefined and are never allowed.
- R4: Array mode reads from the current-descriptor-pointer input. Word i is read at base+2·i, and the first word goes to slot 2. The slot codes are: 0 next-ptr low, 1 next-ptr high, 2 start-addr low, 3 start-addr high, 4 config, 5 X count, 6 X modify, 7 Y count, 8 Y modify.
- R5: Small-list and large-list modes read from the next-pointer input. In small-list mode the first word goes to slot 0 (only the low half of the pointer changes) and later words go to slots 2 upward. In large-list mode words go to slots 0, 1, 2 and so on in order.
- R6: Exactly as many words are read, and strobed, as the descriptor size gives.
- R7: A request stays valid with a stable address until it is accepted. No new request is made while a response is pending, and a word is stored only when `rsp_valid` is high while `rsp_ready` is high.
- R8: The element size is 4 bytes when config[3:2]=2, 2 bytes when config[3:2]=1, and 1 byte otherwise, using the config after any descriptor update. A start address that is not a multiple of the element size makes `err` pulse with `done`, and the current registers are still loaded.
- R9: An X or Y count of 0 is loaded into the current count as 0xFFFF.
- R10: A `start` that arrives while `busy` is high is ignored: it produces no extra `done` and no change to the fetch in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a descriptor pass (ignored while busy) |
| cfg_in | input | 16 | Channel config register |
| next_ptr_in | input | 32 | Next-descriptor pointer register |
| cur_desc_in | input | 32 | Current-descriptor pointer register |
| start_addr_in | input | 32 | Start address register |
| xcnt_in | input | 16 | X count register |
| xmod_in | input | 16 | X modify register |
| ycnt_in | input | 16 | Y count register |
| ymod_in | input | 16 | Y modify register |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 32 | Byte address of the 16-bit word to read |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Sequencer waiting for read data |
| rsp_data | input | 16 | Read data word |
| upd_valid | output | 1 | Working-register update strobe |
| upd_slot | output | 4 | Slot code of the updated register |
| upd_data | output | 16 | Value written |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass flag |
| err | output | 1 | Error flag, valid with done |
| cur_desc_ptr | output | 32 | Current descriptor pointer |
| cur_addr | output | 32 | Current address |
| cur_xcnt | output | 16 | Current X count |
| cur_ycnt | output | 16 | Current Y count |
| wk_cfg | output | 16 | Working config after the pass |
| wk_xmod | output | 16 | Working X modify |
| wk_ymod | output | 16 | Working Y modify |
| elem_bytes | output | 3 | Element size in bytes |

## Verification
The hardest situation to reach from the ports is a descriptor that rewrites the config word in the middle of a fetch. In that case the element size and the alignment error must follow the fetched config and not the value that started the pass. A large-list, size-9 descriptor whose config word selects 32-bit elements and whose start address is only 2-byte aligned checks this, because the launching config selected a different width. Back-pressure is reached by making the bench memory toggle `req_ready` and answer after several idle cycles. A second `start` is pulsed in the middle of such a stalled fetch to check that it is ignored.

// File: rtl/dma_fetch_pkg.sv
package dma_fetch_pkg;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned ADDR_W    = 2 * WORD_W;
  localparam int unsigned SLOT_W    = 4;
  localparam int unsigned NUM_SLOTS = 9;
  localparam int unsigned FLOW_LSB  = 12;
  localparam int unsigned NDS_LSB   = 8;
  localparam int unsigned WS_LSB    = 2;

  localparam logic [2:0] FL_STOP  = 3'd0;
  localparam logic [2:0] FL_AUTO  = 3'd1;
  localparam logic [2:0] FL_ARRAY = 3'd4;
  localparam logic [2:0] FL_SMALL = 3'd6;
  localparam logic [2:0] FL_LARGE = 3'd7;

  localparam int unsigned SL_NLO = 0;
  localparam int unsigned SL_NHI = 1;
  localparam int unsigned SL_SLO = 2;
  localparam int unsigned SL_SHI = 3;
  localparam int unsigned SL_CFG = 4;
  localparam int unsigned SL_XC  = 5;
  localparam int unsigned SL_XM  = 6;
  localparam int unsigned SL_YC  = 7;
  localparam int unsigned SL_YM  = 8;

  typedef enum logic [1:0] {MK_NONE, MK_ARRAY, MK_SMALL, MK_LARGE} kind_e;

  function automatic logic [2:0] bytes_of(input logic [1:0] ws);
    case (ws)
      2'b10:   return 3'd4;
      2'b01:   return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input kind_e k, input logic [SLOT_W-1:0] idx);
    case (k)
      MK_LARGE: return idx;
      MK_SMALL: return (idx == '0) ? SLOT_W'(SL_NLO) : idx + SLOT_W'(1);
      default:  return idx + SLOT_W'(SL_SLO);
    endcase
  endfunction
endpackage

// File: rtl/desc_mode_check.sv
module desc_mode_check
  import dma_fetch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cfg,
  output logic              legal,
  output logic [SLOT_W-1:0] nwords,
  output kind_e             kind,
  output logic              from_cur
);
  logic [2:0]        flow;
  logic [SLOT_W-1:0] nds;

  assign flow   = cfg[FLOW_LSB +: 3];
  assign nds    = cfg[NDS_LSB +: SLOT_W];
  assign nwords = nds;

  always_comb begin
    legal    = 1'b0;
    kind     = MK_NONE;
    from_cur = 1'b0;
    case (flow)
      FL_STOP, FL_AUTO: legal = (nds == '0);
      FL_ARRAY: begin
        legal    = (nds != '0) && (nds <= SLOT_W'(7));
        kind     = MK_ARRAY;
        from_cur = 1'b1;
      end
      FL_SMALL: begin
        legal = (nds != '0) && (nds <= SLOT_W'(8));
        kind  = MK_SMALL;
      end
      FL_LARGE: begin
        legal = (nds != '0) && (nds <= SLOT_W'(9));
        kind  = MK_LARGE;
      end
      default: legal = 1'b0;
    endcase
  end

  // R3: an accepted size never exceeds the slot count
  assert_size_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    legal |-> (nwords <= SLOT_W'(NUM_SLOTS)));
endmodule

// File: rtl/desc_shadow.sv
module desc_shadow
  import dma_fetch_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load,
  input  logic [NUM_SLOTS-1:0][WORD_W-1:0]   init,
  input  logic                               wr_en,
  input  logic [SLOT_W-1:0]                  wr_slot,
  input  logic [WORD_W-1:0]                  wr_data,
  output logic [NUM_SLOTS-1:0][WORD_W-1:0]   words
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  words[g] <= '0;
      else if (load)                               words[g] <= init[g];
      else if (wr_en && wr_slot == SLOT_W'(g))     words[g] <= wr_data;
    end
  end

  // R10: a new snapshot never coincides with a descriptor word write
  assert_no_load_mid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !load);
endmodule

// File: rtl/desc_fetch_ctrl.sv
module desc_fetch_ctrl
  import dma_fetch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              legal,
  input  logic [SLOT_W-1:0] nwords,
  input  kind_e             kind,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              accept,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [WORD_W-1:0] wr_data,
  output logic              fin,
  output logic              bad
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_FIN} st_e;

  st_e               state;
  logic [SLOT_W-1:0] idx, cnt;
  kind_e             kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic              bad_q;

  assign accept    = start && (state == S_IDLE) && !bad_q;
  assign busy      = (state != S_IDLE) || bad_q;
  assign req_valid = (state == S_REQ);
  assign req_addr  = addr_q;
  assign rsp_ready = (state == S_WAIT);
  assign wr_en     = rsp_ready && rsp_valid;
  assign wr_slot   = slot_of(kind_q, idx);
  assign wr_data   = rsp_data;
  assign fin       = (state == S_FIN);
  assign bad       = bad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      idx    <= '0;
      cnt    <= '0;
      kind_q <= MK_NONE;
      addr_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      bad_q <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          kind_q <= kind;
          cnt    <= nwords;
          idx    <= '0;
          addr_q <= base_addr;
          if (!legal)              bad_q <= 1'b1;
          else if (nwords == '0)   state <= S_FIN;
          else                     state <= S_REQ;
        end
        S_REQ: if (req_ready) state <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          idx    <= idx + SLOT_W'(1);
          addr_q <= addr_q + ADDR_W'(2);
          state  <= (idx + SLOT_W'(1) == cnt) ? S_FIN : S_REQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: a pending request keeps valid and address until accepted
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
  // R7: never a new request while a response is awaited
  assert_one_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !req_valid);
  // R3: a rejected combination never reaches the memory port
  assert_bad_nofetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !legal |=> !req_valid && bad);
endmodule

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
  import dma_fetch_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] cfg_in,
  input  logic [31:0] next_ptr_in,
  input  logic [31:0] cur_desc_in,
  input  logic [31:0] start_addr_in,
  input  logic [15:0] xcnt_in,
  input  logic [15:0] xmod_in,
  input  logic [15:0] ycnt_in,
  input  logic [15:0] ymod_in,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [31:0] req_addr,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [15:0] rsp_data,
  output logic        upd_valid,
  output logic [3:0]  upd_slot,
  output logic [15:0] upd_data,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [31:0] cur_desc_ptr,
  output logic [31:0] cur_addr,
  output logic [15:0] cur_xcnt,
  output logic [15:0] cur_ycnt,
  output logic [15:0] wk_cfg,
  output logic [15:0] wk_xmod,
  output logic [15:0] wk_ymod,
  output logic [2:0]  elem_bytes
);
  logic              legal, from_cur, accept, fin, bad;
  logic [SLOT_W-1:0] nwords;
  kind_e             kind;
  logic [NUM_SLOTS-1:0][WORD_W-1:0] init, words;

  desc_mode_check u_check (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_in), .legal(legal),
    .nwords(nwords), .kind(kind), .from_cur(from_cur)
  );

  desc_fetch_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .legal(legal), .nwords(nwords),
    .kind(kind), .base_addr(from_cur ? cur_desc_in : next_ptr_in),
    .accept(accept), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .wr_en(upd_valid), .wr_slot(upd_slot), .wr_data(upd_data),
    .fin(fin), .bad(bad)
  );

  always_comb begin
    init         = '0;
    init[SL_NLO] = next_ptr_in[15:0];
    init[SL_NHI] = next_ptr_in[31:16];
    init[SL_SLO] = start_addr_in[15:0];
    init[SL_SHI] = start_addr_in[31:16];
    init[SL_CFG] = cfg_in;
    init[SL_XC]  = xcnt_in;
    init[SL_XM]  = xmod_in;
    init[SL_YC]  = ycnt_in;
    init[SL_YM]  = ymod_in;
  end

  desc_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .load(accept), .init(init),
    .wr_en(upd_valid), .wr_slot(upd_slot), .wr_data(upd_data), .words(words)
  );

  logic [2:0]  new_bytes;
  logic [2:0]  low_mask;
  logic        misalign;
  logic [31:0] sa_w;

  assign sa_w      = {words[SL_SHI], words[SL_SLO]};
  assign new_bytes = bytes_of(words[SL_CFG][WS_LSB +: 2]);
  assign low_mask  = new_bytes - 3'd1;
  assign misalign  = |(sa_w[2:0] & low_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; err <= 1'b0;
      cur_desc_ptr <= '0; cur_addr <= '0; cur_xcnt <= '0; cur_ycnt <= '0;
      wk_cfg <= '0; wk_xmod <= '0; wk_ymod <= '0; elem_bytes <= '0;
    end else begin
      done <= fin | bad;
      err  <= bad | (fin & misalign);
      if (fin) begin
        cur_desc_ptr <= {words[SL_NHI], words[SL_NLO]};
        cur_addr     <= sa_w;
        cur_xcnt     <= (words[SL_XC] == '0) ? 16'hFFFF : words[SL_XC];
        cur_ycnt     <= (words[SL_YC] == '0) ? 16'hFFFF : words[SL_YC];
        wk_cfg       <= words[SL_CFG];
        wk_xmod      <= words[SL_XM];
        wk_ymod      <= words[SL_YM];
        elem_bytes   <= new_bytes;
      end
    end
  end

  // R9: a clean pass never leaves a zero count
  assert_no_zero_cnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> (cur_xcnt != '0) && (cur_ycnt != '0));
  // R8: a clean pass has an aligned current address
  assert_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err && elem_bytes == 3'd4 |-> cur_addr[1:0] == 2'b00);
  // R2: done is a single-cycle flag
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_dma_desc_fetch.sv
`timescale 1ns/1ps
module tb_dma_desc_fetch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 1'b0;
  logic [15:0] cfg_in = '0, xcnt_in = '0, xmod_in = '0, ycnt_in = '0, ymod_in = '0;
  logic [31:0] next_ptr_in = '0, cur_desc_in = '0, start_addr_in = '0;
  logic        req_valid, req_ready, rsp_valid, rsp_ready, upd_valid, busy, done, err;
  logic [31:0] req_addr, cur_desc_ptr, cur_addr;
  logic [15:0] rsp_data, upd_data, cur_xcnt, cur_ycnt, wk_cfg, wk_xmod, wk_ymod;
  logic [3:0]  upd_slot;
  logic [2:0]  elem_bytes;

  dma_desc_fetch dut (.*);

  // bench memory and logs
  logic [15:0] mem [16];
  logic [31:0] mem_base = '0;
  int          lat = 0;
  logic        stall = 1'b0;
  logic        log_clr = 1'b0;
  logic        pend;
  int          dly;
  logic [31:0] paddr;
  logic        rr_tog;
  logic [31:0] req_log [16];
  logic [3:0]  slot_log [16];
  logic [15:0] data_log [16];
  int          n_req, n_upd, n_done;

  assign req_ready = stall ? rr_tog : 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; dly <= 0; rsp_valid <= 1'b0; rsp_data <= '0; rr_tog <= 1'b0;
      paddr <= '0;
    end else begin
      rr_tog <= ~rr_tog;
      if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0; pend <= 1'b0;
      end else if (pend && dly == 0) begin
        rsp_valid <= 1'b1;
        rsp_data  <= mem[4'((paddr - mem_base) >> 1)];
      end else if (pend) dly <= dly - 1;
      if (req_valid && req_ready) begin
        pend <= 1'b1; dly <= lat; paddr <= req_addr;
      end
    end
  end

  always @(posedge clk) begin
    if (log_clr || !rst_n) begin
      n_req <= 0; n_upd <= 0; n_done <= 0;
    end else begin
      if (req_valid && req_ready) begin
        if (n_req < 16) req_log[n_req] <= req_addr;
        n_req <= n_req + 1;
      end
      if (upd_valid) begin
        if (n_upd < 16) begin slot_log[n_upd] <= upd_slot; data_log[n_upd] <= upd_data; end
        n_upd <= n_upd + 1;
      end
      if (done) n_done <= n_done + 1;
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  task automatic setup(input logic [15:0] c, input logic [31:0] np, input logic [31:0] cd,
                       input logic [31:0] sa, input logic [15:0] xc, input logic [15:0] xm,
                       input logic [15:0] yc, input logic [15:0] ym);
    cfg_in = c; next_ptr_in = np; cur_desc_in = cd; start_addr_in = sa;
    xcnt_in = xc; xmod_in = xm; ycnt_in = yc; ymod_in = ym;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    logic got = 1'b0;
    for (int i = 0; i < 500; i++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
    chk({req, " done seen"}, 32'(got), 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 req_valid", 32'(req_valid), 0);
    chk("R1 upd_valid", 32'(upd_valid), 0);
    chk("R1 cur_addr", cur_addr, 0);
    chk("R1 cur_xcnt", 32'(cur_xcnt), 0);
    chk("R1 elem_bytes", 32'(elem_bytes), 0);
  endtask

  task automatic t_stop();
    clear_logs();
    setup(16'h0008, 32'h2222_0000, 32'h5555_0000, 32'h0000_1000, 16'h0000, 16'h0004, 16'h0005, 16'hFFFC);
    pulse_start();
    wait_done("R2 stop");
    chk("R2 err", 32'(err), 0);
    chk("R2 no requests", n_req, 0);
    chk("R2 cur_desc_ptr", cur_desc_ptr, 32'h2222_0000);
    chk("R2 cur_addr", cur_addr, 32'h0000_1000);
    chk("R9 cur_xcnt zero->max", 32'(cur_xcnt), 32'hFFFF);
    chk("R2 cur_ycnt", 32'(cur_ycnt), 5);
    chk("R2 wk_xmod", 32'(wk_xmod), 4);
    chk("R2 wk_ymod", 32'(wk_ymod), 32'hFFFC);
    chk("R8 elem 4", 32'(elem_bytes), 4);
    @(negedge clk);
    chk("R2 done one cycle", 32'(done), 0);
  endtask

  task automatic t_auto_misalign();
    clear_logs();
    setup(16'h1004, 32'h0000_0100, 32'h0, 32'h0000_1001, 16'h0003, 16'h0002, 16'h0000, 16'h0000);
    pulse_start();
    wait_done("R8 auto");
    chk("R8 misaligned err", 32'(err), 1);
    chk("R8 cur_addr still loaded", cur_addr, 32'h0000_1001);
    chk("R8 elem 2", 32'(elem_bytes), 2);
    chk("R9 cur_ycnt zero->max", 32'(cur_ycnt), 32'hFFFF);
    chk("R2 auto no requests", n_req, 0);
  endtask

  task automatic t_illegal(input logic [15:0] c, input string tag);
    clear_logs();
    setup(c, 32'hDEAD_0000, 32'hBEEF_0000, 32'h0000_7770, 16'h0011, 16'h0001, 16'h0022, 16'h0001);
    pulse_start();
    wait_done({"R3 ", tag});
    chk({"R3 err ", tag}, 32'(err), 1);
    chk({"R3 no requests ", tag}, n_req, 0);
    chk({"R3 cur_addr unchanged ", tag}, cur_addr, 32'h0000_1001);
    chk({"R3 cur_xcnt unchanged ", tag}, 32'(cur_xcnt), 3);
  endtask

  task automatic t_array();
    clear_logs();
    mem_base = 32'h0000_0400; lat = 3; stall = 1'b1;
    mem[0] = 16'h0010; mem[1] = 16'h0003; mem[2] = 16'h4704; mem[3] = 16'h0000;
    mem[4] = 16'h0002; mem[5] = 16'h0009; mem[6] = 16'h0004;
    setup(16'h4700, 32'h0000_0800, 32'h0000_0400, 32'h0, 16'h1, 16'h1, 16'h1, 16'h1);
    pulse_start();
    wait_done("R4 array");
    chk("R6 array word count", n_req, 7);
    chk("R6 array strobe count", n_upd, 7);
    for (int i = 0; i < 7; i++) begin
      chk("R4 array address", req_log[i], 32'h400 + 32'(2 * i));
      chk("R4 array slot", 32'(slot_log[i]), 32'(2 + i));
      chk("R7 array data", 32'(data_log[i]), 32'(mem[i]));
    end
    chk("R4 err", 32'(err), 0);
    chk("R4 cur_addr", cur_addr, 32'h0003_0010);
    chk("R4 cur_desc_ptr", cur_desc_ptr, 32'h0000_0800);
    chk("R9 array xcnt zero->max", 32'(cur_xcnt), 32'hFFFF);
    chk("R4 cur_ycnt", 32'(cur_ycnt), 9);
    chk("R4 wk_ymod", 32'(wk_ymod), 4);
    chk("R8 fetched cfg elem 2", 32'(elem_bytes), 2);
    chk("R4 wk_cfg", 32'(wk_cfg), 32'h4704);
    stall = 1'b0; lat = 0;
  endtask

  task automatic t_small();
    clear_logs();
    mem_base = 32'h0000_1200; lat = 1;
    mem[0] = 16'h1300; mem[1] = 16'h0020; mem[2] = 16'h0005;
    setup(16'h6308, 32'h0000_1200, 32'h9999_0000, 32'hAAAA_BBBB, 16'h0007, 16'h4, 16'h0002, 16'h4);
    pulse_start();
    wait_done("R5 small");
    chk("R6 small word count", n_req, 3);
    chk("R5 small addr0", req_log[0], 32'h1200);
    chk("R5 small addr2", req_log[2], 32'h1204);
    chk("R5 small slot0", 32'(slot_log[0]), 0);
    chk("R5 small slot1", 32'(slot_log[1]), 2);
    chk("R5 small slot2", 32'(slot_log[2]), 3);
    chk("R5 small cur_desc_ptr", cur_desc_ptr, 32'h0000_1300);
    chk("R5 small cur_addr", cur_addr, 32'h0005_0020);
    chk("R5 small err", 32'(err), 0);
    chk("R5 small cur_xcnt", 32'(cur_xcnt), 7);
    lat = 0;
  endtask

  task automatic t_large9();
    clear_logs();
    mem_base = 32'h0000_3000; lat = 2; stall = 1'b1;
    mem[0] = 16'h4444; mem[1] = 16'h0001; mem[2] = 16'h0002; mem[3] = 16'h0000;
    mem[4] = 16'h7908; mem[5] = 16'h0004; mem[6] = 16'h0004; mem[7] = 16'h0000; mem[8] = 16'h0000;
    setup(16'h7900, 32'h0000_3000, 32'h0, 32'h0, 16'h1, 16'h1, 16'h1, 16'h1);
    pulse_start();
    wait_done("R5 large");
    chk("R6 large word count", n_req, 9);
    for (int i = 0; i < 9; i++) chk("R5 large slot order", 32'(slot_log[i]), 32'(i));
    chk("R5 large cur_desc_ptr", cur_desc_ptr, 32'h0001_4444);
    chk("R8 large cur_addr", cur_addr, 32'h0000_0002);
    chk("R8 fetched cfg elem 4", 32'(elem_bytes), 4);
    chk("R8 misaligned vs fetched cfg", 32'(err), 1);
    chk("R9 large ycnt zero->max", 32'(cur_ycnt), 32'hFFFF);
    chk("R5 large cur_xcnt", 32'(cur_xcnt), 4);
    stall = 1'b0; lat = 0;
  endtask

  task automatic t_large2();
    clear_logs();
    mem_base = 32'h0000_0600;
    mem[0] = 16'h0A0A; mem[1] = 16'h0B0B;
    setup(16'h7200, 32'h0000_0600, 32'h0, 32'h0000_0C00, 16'h0010, 16'h1, 16'h0020, 16'h1);
    pulse_start();
    wait_done("R6 large2");
    chk("R6 large2 word count", n_req, 2);
    chk("R6 large2 strobes", n_upd, 2);
    chk("R6 large2 cur_desc_ptr", cur_desc_ptr, 32'h0B0B_0A0A);
    chk("R6 large2 cur_addr from input", cur_addr, 32'h0000_0C00);
    chk("R6 large2 elem", 32'(elem_bytes), 1);
  endtask

  task automatic t_busy_start();
    clear_logs();
    mem_base = 32'h0000_0400; lat = 4; stall = 1'b1;
    mem[0] = 16'h0040; mem[1] = 16'h0000;
    setup(16'h4208, 32'h0000_0900, 32'h0000_0400, 32'h0, 16'h0005, 16'h4, 16'h0006, 16'h4);
    pulse_start();
    repeat (3) @(negedge clk);
    chk("R10 busy during fetch", 32'(busy), 1);
    setup(16'h0000, 32'h7777_0000, 32'h0, 32'h0000_5550, 16'h1, 16'h1, 16'h1, 16'h1);
    pulse_start();
    wait_done("R10 busy");
    repeat (10) @(negedge clk);
    chk("R10 single done", n_done, 1);
    chk("R10 word count", n_req, 2);
    chk("R10 cur_addr from first pass", cur_addr, 32'h0000_0040);
    chk("R10 cur_desc_ptr from first pass", cur_desc_ptr, 32'h0000_0900);
    stall = 1'b0; lat = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stop();
    t_auto_misalign();
    t_illegal(16'h0100, "stop size1");
    t_illegal(16'h4000, "array size0");
    t_illegal(16'h4800, "array size8");
    t_illegal(16'h6900, "small size9");
    t_illegal(16'h7A00, "large size10");
    t_illegal(16'h2100, "undefined mode");
    t_array();
    t_small();
    t_large9();
    t_large2();
    t_busy_start();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
    $finish;
  end
endmodule